// File: doc/BRIEF.md
# Mixed-polarity event interrupt controller

This block collects one-cycle hardware event pulses from three sources and turns them into sticky status bits that software inspects and clears over a simple word-addressed read/write bus. The first source carries three link events: leaving the L2 low-power state, leaving a hot reset, and the data link coming up. Their status bits and their enable bits share one register word. The other two sources carry error reports from the error-correcting logic of four data buffers. One group reports single-bit (corrected) errors and the other reports double-bit (uncorrectable) errors. Each of these groups has its own status register and a separate mask register in which a 1 blocks the interrupt.

All unmasked or enabled status bits are ORed onto one interrupt output. Each error group also feeds a saturating counter. The counter adds the number of error lanes that pulse in a cycle, and software resets it by writing zero.

Top module: `hw_event_irq_hub`

## Requirements
- R1: After reset every status bit reads 0, both counters read 0, the three link enables read 0, both mask registers read 0xFFFF (all lanes masked), and `irq_o` is 0.
- R2: A pulse on `link_evt_i[k]` sets bit k of the link register at offset 0x14C. Bit 0 is L2 exit, bit 1 is hot-reset exit and bit 2 is link-up exit. Bits 18:16 of the same word hold the enables for those events in the same order.
- R3: A write to the link register clears each status bit whose `bus_wdata_i` bit in 2:0 is 1. The same write loads bits 18:16 of the data into the enables, whatever is written to the status bits.
- R4: A set link status bit drives `irq_o` only while its enable bit is 1.
- R5: A pulse on lane i of `sec_evt_i` (or of `ded_evt_i`) sets bit i of the single-error status at 0x28 (or of the double-error status at 0x30). The lanes form four 4-bit buffer fields: transmit 3:0, receive 7:4, inbound bridge 11:8 and outbound bridge 15:12. Writing 1 to a status bit clears it.
- R6: The mask registers at 0x2C (single) and 0x34 (double) hold one bit per lane in bits 15:0. A 1 keeps the matching status bit from driving `irq_o`, and a 0 lets it through.
- R7: If an event pulse arrives in the same cycle as a write that clears that status bit, the bit stays set.
- R8: The single-error counter at 0x20 and the double-error counter at 0x24 each add, every cycle, the number of lanes of their group that pulse in that cycle. Each counter saturates at all ones (255 with an 8-bit counter).
- R9: Writing 0 to a counter resets it. Lanes that pulse in that same cycle are counted from zero. Writing a nonzero value to a counter leaves it unchanged.
- R10: `irq_o` is the OR of all enabled link bits and all unmasked error bits. A read of any address that is not one of the seven registers returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational; 0 when no read is in progress) |
| link_evt_i | input | 3 | Link event pulses |
| sec_evt_i | input | NUM_BUFS*FIELD_W | Single-bit error pulses, one per lane |
| ded_evt_i | input | NUM_BUFS*FIELD_W | Double-bit error pulses, one per lane |
| irq_o | output | 1 | Merged interrupt request |

## Verification
The link group is swept over all eight event patterns with the enables off, and then over all eight enable patterns against each single event. This separates the status path from the enable gating and shows that a clearing write keeps the enables it carries. Every error lane of both groups is pulsed on its own and then tried against a mask that passes only that lane and a mask that blocks only that lane. This catches a swapped field, a swapped group or an inverted mask polarity. Multi-lane bursts drive a narrow counter from a known value past its ceiling. Writes made in the same cycle as a pulse show that a new event wins over a clear, and that a zero write still counts the lanes that pulse with it.

// File: rtl/evtirq_pkg.sv
package evtirq_pkg;

  localparam int DATA_W      = 32;
  localparam int LINK_EVTS   = 3;
  localparam int LINK_EN_LSB = 16;

  // Register byte offsets (fixed by the software view of the block)
  localparam int OFF_SEC_CNT = 'h020;
  localparam int OFF_DED_CNT = 'h024;
  localparam int OFF_SEC_ST  = 'h028;
  localparam int OFF_SEC_MSK = 'h02C;
  localparam int OFF_DED_ST  = 'h030;
  localparam int OFF_DED_MSK = 'h034;
  localparam int OFF_LINK    = 'h14C;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_SEC_CNT,
    RS_DED_CNT,
    RS_SEC_ST,
    RS_SEC_MSK,
    RS_DED_ST,
    RS_DED_MSK,
    RS_LINK
  } reg_sel_e;

endpackage

// File: rtl/evtirq_link_group.sv
module evtirq_link_group #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         wr_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_wdata_i,
  output logic [N-1:0] st_o,
  output logic [N-1:0] en_o,
  output logic         req_o
);

  logic [N-1:0] st_q, st_d;
  logic [N-1:0] en_q, en_d;
  logic [N-1:0] clr_mask;

  always_comb begin
    clr_mask = wr_i ? clr_i : '0;
    // a fresh event outranks a clear in the same cycle
    st_d     = (st_q & ~clr_mask) | evt_i;
    en_d     = wr_i ? en_wdata_i : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      st_q <= st_d;
      if (wr_i) en_q <= en_d;
    end
  end

  assign st_o  = st_q;
  assign en_o  = en_q;
  assign req_o = |(st_q & en_q);

endmodule

// File: rtl/evtirq_ecc_group.sv
module evtirq_ecc_group #(
  parameter int LANES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] evt_i,
  input  logic             st_wr_i,
  input  logic             msk_wr_i,
  input  logic [LANES-1:0] wdata_i,
  output logic [LANES-1:0] st_o,
  output logic [LANES-1:0] msk_o,
  output logic             req_o
);

  logic [LANES-1:0] st_q, st_d;
  logic [LANES-1:0] msk_q, msk_d;

  always_comb begin
    st_d  = (st_q & ~(st_wr_i ? wdata_i : '0)) | evt_i;
    msk_d = msk_wr_i ? wdata_i : msk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      msk_q <= '1;
    end else begin
      st_q <= st_d;
      if (msk_wr_i) msk_q <= msk_d;
    end
  end

  assign st_o  = st_q;
  assign msk_o = msk_q;
  // mask bit high blocks the lane
  assign req_o = |(st_q & ~msk_q);

endmodule

// File: rtl/evtirq_err_counter.sv
module evtirq_err_counter #(
  parameter int LANES = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] evt_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam int INC_W = $clog2(LANES + 1);
  localparam int SUM_W = ((CNT_W > INC_W) ? CNT_W : INC_W) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, base;
  logic [INC_W-1:0] inc;
  logic [SUM_W-1:0] sum;
  logic             cnt_en;

  always_comb begin
    inc    = INC_W'($countones(evt_i));
    base   = clr_i ? '0 : cnt_q;
    sum    = SUM_W'(base) + SUM_W'(inc);
    cnt_d  = (sum > SUM_W'(CNT_MAX)) ? CNT_MAX : sum[CNT_W-1:0];
    cnt_en = clr_i | (|evt_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/hw_event_irq_hub.sv
module hw_event_irq_hub
  import evtirq_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int CNT_W    = 16,
  parameter int NUM_BUFS = 4,
  parameter int FIELD_W  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_sel_i,
  input  logic                        bus_wr_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic [31:0]                 bus_wdata_i,
  output logic [31:0]                 bus_rdata_o,
  input  logic [2:0]                  link_evt_i,
  input  logic [NUM_BUFS*FIELD_W-1:0] sec_evt_i,
  input  logic [NUM_BUFS*FIELD_W-1:0] ded_evt_i,
  output logic                        irq_o
);

  localparam int LANES = NUM_BUFS * FIELD_W;
  localparam int NGRP  = 2;

  reg_sel_e    sel_d;
  logic        bus_we;
  logic [31:0] rd_d;

  logic [LANES-1:0] grp_evt [NGRP];
  logic [LANES-1:0] grp_st  [NGRP];
  logic [LANES-1:0] grp_msk [NGRP];
  logic [CNT_W-1:0] grp_cnt [NGRP];
  logic [NGRP-1:0]  grp_req, grp_st_wr, grp_msk_wr, grp_cnt_clr;

  logic [LINK_EVTS-1:0] link_st, link_en;
  logic                 link_req, link_wr;
  logic [LANES-1:0]     sec_st, sec_msk, ded_st, ded_msk;
  logic [CNT_W-1:0]     sec_cnt, ded_cnt;

  // address decode
  always_comb begin
    if      (bus_addr_i == ADDR_W'(OFF_SEC_CNT)) sel_d = RS_SEC_CNT;
    else if (bus_addr_i == ADDR_W'(OFF_DED_CNT)) sel_d = RS_DED_CNT;
    else if (bus_addr_i == ADDR_W'(OFF_SEC_ST))  sel_d = RS_SEC_ST;
    else if (bus_addr_i == ADDR_W'(OFF_SEC_MSK)) sel_d = RS_SEC_MSK;
    else if (bus_addr_i == ADDR_W'(OFF_DED_ST))  sel_d = RS_DED_ST;
    else if (bus_addr_i == ADDR_W'(OFF_DED_MSK)) sel_d = RS_DED_MSK;
    else if (bus_addr_i == ADDR_W'(OFF_LINK))    sel_d = RS_LINK;
    else                                         sel_d = RS_NONE;
  end

  assign bus_we  = bus_sel_i & bus_wr_i;
  assign link_wr = bus_we & (sel_d == RS_LINK);

  evtirq_link_group #(.N(LINK_EVTS)) u_link (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (link_evt_i),
    .wr_i       (link_wr),
    .clr_i      (bus_wdata_i[LINK_EVTS-1:0]),
    .en_wdata_i (bus_wdata_i[LINK_EN_LSB +: LINK_EVTS]),
    .st_o       (link_st),
    .en_o       (link_en),
    .req_o      (link_req)
  );

  // group 0: single-bit errors, group 1: double-bit errors
  for (genvar g = 0; g < NGRP; g++) begin : g_err
    localparam reg_sel_e SEL_ST  = (g == 0) ? RS_SEC_ST  : RS_DED_ST;
    localparam reg_sel_e SEL_MSK = (g == 0) ? RS_SEC_MSK : RS_DED_MSK;
    localparam reg_sel_e SEL_CNT = (g == 0) ? RS_SEC_CNT : RS_DED_CNT;

    assign grp_evt[g]     = (g == 0) ? sec_evt_i : ded_evt_i;
    assign grp_st_wr[g]   = bus_we & (sel_d == SEL_ST);
    assign grp_msk_wr[g]  = bus_we & (sel_d == SEL_MSK);
    assign grp_cnt_clr[g] = bus_we & (sel_d == SEL_CNT) & (bus_wdata_i == '0);

    evtirq_ecc_group #(.LANES(LANES)) u_grp (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (grp_evt[g]),
      .st_wr_i  (grp_st_wr[g]),
      .msk_wr_i (grp_msk_wr[g]),
      .wdata_i  (bus_wdata_i[LANES-1:0]),
      .st_o     (grp_st[g]),
      .msk_o    (grp_msk[g]),
      .req_o    (grp_req[g])
    );

    evtirq_err_counter #(.LANES(LANES), .CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .evt_i (grp_evt[g]),
      .clr_i (grp_cnt_clr[g]),
      .cnt_o (grp_cnt[g])
    );
  end

  assign sec_st  = grp_st[0];
  assign sec_msk = grp_msk[0];
  assign sec_cnt = grp_cnt[0];
  assign ded_st  = grp_st[1];
  assign ded_msk = grp_msk[1];
  assign ded_cnt = grp_cnt[1];

  // read mux
  always_comb begin
    rd_d = '0;
    case (sel_d)
      RS_SEC_CNT: rd_d = 32'(sec_cnt);
      RS_DED_CNT: rd_d = 32'(ded_cnt);
      RS_SEC_ST:  rd_d = 32'(sec_st);
      RS_SEC_MSK: rd_d = 32'(sec_msk);
      RS_DED_ST:  rd_d = 32'(ded_st);
      RS_DED_MSK: rd_d = 32'(ded_msk);
      RS_LINK: begin
        rd_d[LINK_EVTS-1:0]               = link_st;
        rd_d[LINK_EN_LSB +: LINK_EVTS]    = link_en;
      end
      default:    rd_d = '0;
    endcase
  end

  assign bus_rdata_o = (bus_sel_i & ~bus_wr_i) ? rd_d : '0;
  assign irq_o       = link_req | (|grp_req);

endmodule

// File: rtl/evtirq_checker.sv
module evtirq_checker
  import evtirq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 16,
  parameter int LANES  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel_i,
  input logic             bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]      bus_wdata_i,
  input logic [2:0]       link_evt_i,
  input logic [LANES-1:0] sec_evt_i,
  input logic [LANES-1:0] ded_evt_i,
  input logic             irq_o,
  input logic [2:0]       link_st,
  input logic [LANES-1:0] sec_st,
  input logic [LANES-1:0] sec_msk,
  input logic [LANES-1:0] ded_st,
  input logic [LANES-1:0] ded_msk,
  input logic [CNT_W-1:0] sec_cnt
);

  logic sec_st_wr, sec_cnt_wr;
  assign sec_st_wr  = bus_sel_i & bus_wr_i & (bus_addr_i == ADDR_W'(OFF_SEC_ST));
  assign sec_cnt_wr = bus_sel_i & bus_wr_i & (bus_addr_i == ADDR_W'(OFF_SEC_CNT))
                      & (bus_wdata_i == '0);

  // R2 / R7: a link pulse always lands in status
  p_link_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (link_evt_i != 0) |=> ((link_st & $past(link_evt_i)) == $past(link_evt_i)));

  // R5: error pulses land in their group's status
  p_sec_sticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_evt_i != 0) |=> ((sec_st & $past(sec_evt_i)) == $past(sec_evt_i)));

  p_ded_sticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ded_evt_i != 0) |=> ((ded_st & $past(ded_evt_i)) == $past(ded_evt_i)));

  // R3: write-one-to-clear when no event competes
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_st_wr |=> ((sec_st & $past(bus_wdata_i[LANES-1:0] & ~sec_evt_i)) == '0));

  // R8: counter never decreases unless cleared
  p_cnt_monotone_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_cnt_wr |=> (sec_cnt >= $past(sec_cnt)));

  p_cnt_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((&sec_cnt) && !sec_cnt_wr) |=> $stable(sec_cnt));

  // R6 / R10: unmasked error forces irq, irq needs a source
  p_unmasked_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (((sec_st & ~sec_msk) != 0) || ((ded_st & ~ded_msk) != 0)) |-> irq_o);

  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((link_st != 0) || ((sec_st & ~sec_msk) != 0) || ((ded_st & ~ded_msk) != 0)));

endmodule

bind hw_event_irq_hub evtirq_checker #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W),
  .LANES  (NUM_BUFS * FIELD_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel_i   (bus_sel_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .link_evt_i  (link_evt_i),
  .sec_evt_i   (sec_evt_i),
  .ded_evt_i   (ded_evt_i),
  .irq_o       (irq_o),
  .link_st     (link_st),
  .sec_st      (sec_st),
  .sec_msk     (sec_msk),
  .ded_st      (ded_st),
  .ded_msk     (ded_msk),
  .sec_cnt     (sec_cnt)
);

// File: tb/sim_hw_event_irq_hub.sv
`timescale 1ns/1ps
module sim_hw_event_irq_hub;

  localparam int AW = 12;
  localparam int CW = 8;
  localparam int LN = 16;
  localparam int CMAX = 255;

  localparam logic [AW-1:0] A_SCNT = 12'h020;
  localparam logic [AW-1:0] A_DCNT = 12'h024;
  localparam logic [AW-1:0] A_SST  = 12'h028;
  localparam logic [AW-1:0] A_SMSK = 12'h02C;
  localparam logic [AW-1:0] A_DST  = 12'h030;
  localparam logic [AW-1:0] A_DMSK = 12'h034;
  localparam logic [AW-1:0] A_LINK = 12'h14C;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          bus_sel, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [2:0]    link_evt;
  logic [LN-1:0] sec_evt, ded_evt;
  logic          irq;

  hw_event_irq_hub #(.ADDR_W(AW), .CNT_W(CW), .NUM_BUFS(4), .FIELD_W(4)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel_i   (bus_sel),
    .bus_wr_i    (bus_wr),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .link_evt_i  (link_evt),
    .sec_evt_i   (sec_evt),
    .ded_evt_i   (ded_evt),
    .irq_o       (irq)
  );

  int n_run = 0;
  int n_fail = 0;
  int sec_exp = 0;
  int ded_exp = 0;
  bit done = 1'b0;

  function automatic int sat(int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_pulse(logic [AW-1:0] a, logic [31:0] d,
                          logic [2:0] l, logic [LN-1:0] s, logic [LN-1:0] e);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    link_evt = l; sec_evt = s; ded_evt = e;
    step();
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    link_evt = '0; sec_evt = '0; ded_evt = '0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    wr_pulse(a, d, '0, '0, '0);
  endtask

  task automatic pulse(logic [2:0] l, logic [LN-1:0] s, logic [LN-1:0] e);
    link_evt = l; sec_evt = s; ded_evt = e;
    step();
    link_evt = '0; sec_evt = '0; ded_evt = '0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] v);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    v = bus_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    link_evt = '0; sec_evt = '0; ded_evt = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();

    // R1 reset state
    rd(A_LINK, v); chk("R1 link", v, 32'h0);
    rd(A_SST,  v); chk("R1 sec status", v, 32'h0);
    rd(A_DST,  v); chk("R1 ded status", v, 32'h0);
    rd(A_SMSK, v); chk("R1 sec mask", v, 32'hFFFF);
    rd(A_DMSK, v); chk("R1 ded mask", v, 32'hFFFF);
    rd(A_SCNT, v); chk("R1 sec count", v, 32'h0);
    rd(A_DCNT, v); chk("R1 ded count", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R10 unmapped addresses
    rd(12'h040, v); chk("R10 unmapped 0x040", v, 32'h0);
    rd(12'h150, v); chk("R10 unmapped 0x150", v, 32'h0);

    // R2/R3/R4: all link patterns with enables off
    for (int p = 0; p < 8; p++) begin
      pulse(3'(p), '0, '0);
      rd(A_LINK, v); chk("R2 link status", v, 32'(p));
      chk("R4 disabled irq", {31'b0, irq}, 32'h0);
      wr(A_LINK, 32'(p));
      rd(A_LINK, v); chk("R3 link cleared", v, 32'h0);
    end

    // R3/R4: every enable pattern against each single event
    for (int en = 0; en < 8; en++) begin
      for (int b = 0; b < 3; b++) begin
        wr(A_LINK, 32'(en) << 16);
        pulse(3'(1 << b), '0, '0);
        chk("R4 enable gating", {31'b0, irq}, 32'((en >> b) & 1));
        rd(A_LINK, v); chk("R2 link with enables", v, (32'(en) << 16) | 32'(1 << b));
        wr(A_LINK, (32'(en) << 16) | 32'h7);
        rd(A_LINK, v); chk("R3 enables kept on clear", v, 32'(en) << 16);
      end
    end
    wr(A_LINK, 32'h0);

    // R5/R6: each lane of both error groups
    for (int g = 0; g < 2; g++) begin
      for (int l = 0; l < LN; l++) begin
        logic [LN-1:0] bitv;
        logic [AW-1:0] st_a, mk_a;
        bitv = LN'(1) << l;
        st_a = (g == 0) ? A_SST : A_DST;
        mk_a = (g == 0) ? A_SMSK : A_DMSK;
        if (g == 0) begin pulse('0, bitv, '0); sec_exp = sat(sec_exp + 1); end
        else        begin pulse('0, '0, bitv); ded_exp = sat(ded_exp + 1); end
        rd(st_a, v); chk("R5 lane position", v, 32'(bitv));
        chk("R6 masked irq", {31'b0, irq}, 32'h0);
        wr(mk_a, 32'(~bitv));
        chk("R6 lane unmasked irq", {31'b0, irq}, 32'h1);
        wr(mk_a, 32'(bitv));
        chk("R6 lane masked irq", {31'b0, irq}, 32'h0);
        wr(st_a, 32'(bitv));
        rd(st_a, v); chk("R5 status cleared", v, 32'h0);
        wr(mk_a, 32'hFFFF);
      end
    end
    rd(A_SCNT, v); chk("R8 sec count after sweep", v, 32'(sec_exp));
    rd(A_DCNT, v); chk("R8 ded count after sweep", v, 32'(ded_exp));

    // R7: event during clear wins
    pulse('0, 16'h0004, '0); sec_exp = sat(sec_exp + 1);
    wr_pulse(A_SST, 32'h4, '0, 16'h0004, '0); sec_exp = sat(sec_exp + 1);
    rd(A_SST, v); chk("R7 sec set beats clear", v, 32'h4);
    wr(A_SST, 32'h4);
    rd(A_SST, v); chk("R7 sec later clear", v, 32'h0);
    pulse(3'b010, '0, '0);
    wr_pulse(A_LINK, 32'h0005_0002, 3'b010, '0, '0);
    rd(A_LINK, v); chk("R7 link set beats clear", v, 32'h0005_0002);
    wr(A_LINK, 32'h7);
    rd(A_LINK, v); chk("R7 link later clear", v, 32'h0);
    rd(A_SCNT, v); chk("R8 sec count", v, 32'(sec_exp));

    // R8/R9: counter bursts and saturation
    wr(A_SCNT, 32'h0); sec_exp = 0;
    rd(A_SCNT, v); chk("R9 zero write clears", v, 32'h0);
    for (int i = 0; i < 15; i++) begin
      pulse('0, 16'hFFFF, '0); sec_exp = sat(sec_exp + 16);
    end
    rd(A_SCNT, v); chk("R8 burst count 240", v, 32'd240);
    pulse('0, 16'h0F00, '0); sec_exp = sat(sec_exp + 4);
    rd(A_SCNT, v); chk("R8 partial burst 244", v, 32'd244);
    pulse('0, 16'hFFFF, '0);
    rd(A_SCNT, v); chk("R8 saturate", v, 32'd255);
    pulse('0, 16'hFFFF, '0);
    rd(A_SCNT, v); chk("R8 hold at ceiling", v, 32'd255);
    wr(A_SCNT, 32'h5);
    rd(A_SCNT, v); chk("R9 nonzero write ignored", v, 32'd255);
    wr_pulse(A_SCNT, 32'h0, '0, 16'h0007, '0);
    rd(A_SCNT, v); chk("R9 clear counts same-cycle lanes", v, 32'd3);
    wr(A_SST, 32'hFFFF);
    wr(A_DCNT, 32'h0);
    pulse('0, '0, 16'hA5A5);
    rd(A_DCNT, v); chk("R8 ded burst", v, 32'd8);
    rd(A_SCNT, v); chk("R8 sec untouched by ded", v, 32'd3);

    // R10: irq merge
    wr(A_DMSK, 32'h0);
    chk("R10 ded unmasked irq", {31'b0, irq}, 32'h1);
    wr(A_DST, 32'hFFFF);
    chk("R10 irq drops", {31'b0, irq}, 32'h0);
    wr(A_LINK, 32'h0004_0000);
    pulse(3'b100, 16'h0001, '0);
    chk("R10 link and masked sec", {31'b0, irq}, 32'h1);
    wr(A_LINK, 32'h7);
    chk("R10 only masked sec left", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule